// File: doc/BRIEF.md
# Predicate mask lookup unit

This unit finds the per-element predicate mask for one operand of a vectorised instruction. The mask is found by indirection, not taken from a fixed register. Software fills a small bank of configuration slots. Each slot names an operand register and the register file it belongs to, integer or floating-point. It also names an integer register that holds the mask bits, and carries two flags: one inverts the mask, the other makes inactive elements be zeroed instead of skipped.

A rebuild pulse turns the slot bank into two lookup tables of 32 entries, one for the integer operand registers and one for the floating-point operand registers. Both tables are cleared first, and then every slot in use is applied, from slot 0 upward. A lookup names an operand register and its file. The unit drives the integer register read port in the same cycle. One cycle later it returns the effective mask, limited to the current vector length, together with the zeroing flag. An operand with no table entry gets an all-ones mask (within the vector length) and no zeroing. The ALU and the element issue logic that use the result are outside this unit.

Top module: `predmask_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and both tables are empty, so every lookup returns the unpredicated result until the first rebuild.
- R2: A configuration write (`cfg_we`) stores the slot fields at index `cfg_slot` but does not change any lookup result until the next `rebuild`.
- R3: On `rebuild`, both tables are cleared and every slot with `cfg_used`=1 is then written to the table entry its key selects. When two slots name the same file and key, the higher slot index wins.
- R4: The type bit selects the table: `cfg_is_fp`=0 writes the integer table and 1 writes the floating-point table. A lookup with `lk_is_fp` reads only the matching table.
- R5: In the request cycle, `rd_en` is 1 exactly when `lk_valid` is 1 and the selected entry is enabled, and `rd_addr` then equals that entry's mask register. `rd_en` is 0 when no lookup is requested.
- R6: When the entry's invert bit is set, the returned mask is the bitwise inverse of `rd_data`. Otherwise it is `rd_data` unchanged (before length limiting).
- R7: `res_zero` equals the zero bit of an enabled entry and is 0 for an entry that is not enabled.
- R8: A lookup that hits an entry that is not enabled returns an all-ones mask (before length limiting) with `res_zero`=0.
- R9: Mask bit b is forced to 0 when b >= `lk_vl`. When `lk_vl` >= XLEN, no bit is cleared.
- R10: `res_valid` is 1 in the cycle after a cycle with `lk_valid`=1 and is 0 otherwise. The mask and zero result belong to that request.
- R11: A slot with `cfg_used`=0 is not applied at rebuild, and its key stays unpredicated unless another slot names it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write configuration slot |
| cfg_slot | input | $clog2(NUM_CFG) | Slot index to write |
| cfg_used | input | 1 | Slot takes part in rebuild |
| cfg_is_fp | input | 1 | Slot targets floating-point table (else integer) |
| cfg_key | input | 5 | Operand register number that is predicated |
| cfg_src | input | 5 | Integer register holding the mask |
| cfg_inv | input | 1 | Invert the mask |
| cfg_zero | input | 1 | Zero inactive elements instead of skipping |
| rebuild | input | 1 | Clear tables and apply all used slots |
| lk_valid | input | 1 | Lookup request |
| lk_is_fp | input | 1 | Operand belongs to floating-point file |
| lk_reg | input | 5 | Operand register number |
| lk_vl | input | $clog2(XLEN+1) | Current vector length |
| rd_en | output | 1 | Integer register read enable |
| rd_addr | output | 5 | Integer register read address |
| rd_data | input | XLEN | Integer register read data, same cycle |
| res_valid | output | 1 | Result valid |
| res_mask | output | XLEN | Effective predicate mask |
| res_zero | output | 1 | Zero inactive elements |

## Verification
The bench builds the unit with XLEN=8 and NUM_CFG=4. With these values every operand register of both files, and every vector length from 0 through past the mask width, can be swept after each rebuild. The small slot bank is enough to set up an override of the same key, the same key in both files, a slot that is not in use, and a reconfiguration that must clear the old entries. Masks are predicted from an arithmetic register-file model in the bench.

// File: rtl/predmask_pkg.sv
package predmask_pkg;

    localparam int REG_AW   = 5;
    localparam int NUM_REGS = 1 << REG_AW;

    // One configuration slot as written by software.
    typedef struct packed {
        logic              used;
        logic              is_fp;
        logic [REG_AW-1:0] key;
        logic [REG_AW-1:0] src;
        logic              inv;
        logic              zero;
    } pcfg_t;

    // One entry of a lookup table, indexed by operand register.
    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] src;
        logic              inv;
        logic              zero;
    } ptab_t;

endpackage

// File: rtl/predmask_cfg_store.sv
module predmask_cfg_store
    import predmask_pkg::*;
#(
    parameter int NUM_CFG = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NUM_CFG)-1:0] wr_idx,
    input  pcfg_t                      wr_data,
    output pcfg_t [NUM_CFG-1:0]        slots
);

    typedef struct packed {
        pcfg_t [NUM_CFG-1:0] slot;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.slot[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign slots = s_q.slot;

endmodule

// File: rtl/predmask_table.sv
module predmask_table
    import predmask_pkg::*;
#(
    parameter int NUM_CFG = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rebuild,
    input  pcfg_t [NUM_CFG-1:0]  slots,
    output ptab_t [NUM_REGS-1:0] int_tab,
    output ptab_t [NUM_REGS-1:0] fp_tab
);

    typedef struct packed {
        ptab_t [NUM_REGS-1:0] itab;
        ptab_t [NUM_REGS-1:0] ftab;
    } state_t;

    state_t t_d, t_q;

    // Clear, then apply slots in ascending order: a later slot overwrites.
    always_comb begin
        t_d = t_q;
        if (rebuild) begin
            t_d = '0;
            for (int i = 0; i < NUM_CFG; i++) begin
                if (slots[i].used) begin
                    if (slots[i].is_fp) begin
                        t_d.ftab[slots[i].key].en   = 1'b1;
                        t_d.ftab[slots[i].key].src  = slots[i].src;
                        t_d.ftab[slots[i].key].inv  = slots[i].inv;
                        t_d.ftab[slots[i].key].zero = slots[i].zero;
                    end else begin
                        t_d.itab[slots[i].key].en   = 1'b1;
                        t_d.itab[slots[i].key].src  = slots[i].src;
                        t_d.itab[slots[i].key].inv  = slots[i].inv;
                        t_d.itab[slots[i].key].zero = slots[i].zero;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign int_tab = t_q.itab;
    assign fp_tab  = t_q.ftab;

endmodule

// File: rtl/predmask_select.sv
module predmask_select
    import predmask_pkg::*;
(
    input  logic                 lk_valid,
    input  logic                 lk_is_fp,
    input  logic [REG_AW-1:0]    lk_reg,
    input  ptab_t [NUM_REGS-1:0] int_tab,
    input  ptab_t [NUM_REGS-1:0] fp_tab,
    output ptab_t                ent,
    output logic                 rd_en,
    output logic [REG_AW-1:0]    rd_addr
);

    always_comb begin
        ent     = lk_is_fp ? fp_tab[lk_reg] : int_tab[lk_reg];
        rd_en   = lk_valid & ent.en;
        rd_addr = ent.en ? ent.src : '0;
    end

endmodule

// File: rtl/predmask_shape.sv
module predmask_shape
    import predmask_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VL_W = 6
) (
    input  ptab_t            ent,
    input  logic [XLEN-1:0]  raw,
    input  logic [VL_W-1:0]  vl,
    output logic [XLEN-1:0]  mask,
    output logic             zero
);

    logic [XLEN-1:0] lim;
    logic [XLEN-1:0] base;

    for (genvar b = 0; b < XLEN; b++) begin : g_lim
        assign lim[b] = (b < int'(vl));
    end

    always_comb begin
        if (!ent.en) begin
            base = '1;
        end else if (ent.inv) begin
            base = ~raw;
        end else begin
            base = raw;
        end
        mask = base & lim;
        zero = ent.en & ent.zero;
    end

endmodule

// File: rtl/predmask_unit.sv
module predmask_unit
    import predmask_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_CFG = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_CFG)-1:0] cfg_slot,
    input  logic                       cfg_used,
    input  logic                       cfg_is_fp,
    input  logic [4:0]                 cfg_key,
    input  logic [4:0]                 cfg_src,
    input  logic                       cfg_inv,
    input  logic                       cfg_zero,
    input  logic                       rebuild,
    input  logic                       lk_valid,
    input  logic                       lk_is_fp,
    input  logic [4:0]                 lk_reg,
    input  logic [$clog2(XLEN+1)-1:0]  lk_vl,
    output logic                       rd_en,
    output logic [4:0]                 rd_addr,
    input  logic [XLEN-1:0]            rd_data,
    output logic                       res_valid,
    output logic [XLEN-1:0]            res_mask,
    output logic                       res_zero
);

    localparam int VL_W = $clog2(XLEN + 1);

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] mask;
        logic            zero;
    } res_t;

    pcfg_t                wr_data;
    pcfg_t [NUM_CFG-1:0]  slots;
    ptab_t [NUM_REGS-1:0] int_tab;
    ptab_t [NUM_REGS-1:0] fp_tab;
    ptab_t                ent;
    logic [XLEN-1:0]      mask_c;
    logic                 zero_c;
    res_t                 r_d, r_q;

    assign wr_data = '{used: cfg_used, is_fp: cfg_is_fp, key: cfg_key,
                       src: cfg_src, inv: cfg_inv, zero: cfg_zero};

    predmask_cfg_store #(.NUM_CFG(NUM_CFG)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_slot),
        .wr_data (wr_data),
        .slots   (slots)
    );

    predmask_table #(.NUM_CFG(NUM_CFG)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rebuild (rebuild),
        .slots   (slots),
        .int_tab (int_tab),
        .fp_tab  (fp_tab)
    );

    predmask_select u_select (
        .lk_valid (lk_valid),
        .lk_is_fp (lk_is_fp),
        .lk_reg   (lk_reg),
        .int_tab  (int_tab),
        .fp_tab   (fp_tab),
        .ent      (ent),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr)
    );

    predmask_shape #(.XLEN(XLEN), .VL_W(VL_W)) u_shape (
        .ent  (ent),
        .raw  (rd_data),
        .vl   (lk_vl),
        .mask (mask_c),
        .zero (zero_c)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = lk_valid;
        if (lk_valid) begin
            r_d.mask = mask_c;
            r_d.zero = zero_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign res_valid = r_q.valid;
    assign res_mask  = r_q.mask;
    assign res_zero  = r_q.zero;

endmodule

// File: rtl/predmask_unit_chk.sv
module predmask_unit_chk #(
    parameter int XLEN = 32,
    parameter int VL_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VL_W-1:0] lk_vl,
    input logic            rd_en,
    input logic            res_valid,
    input logic [XLEN-1:0] res_mask,
    input logic            res_zero
);

    function automatic logic [XLEN-1:0] lim_of(input logic [VL_W-1:0] v);
        logic [XLEN-1:0] m;
        for (int b = 0; b < XLEN; b++) m[b] = (b < int'(v));
        return m;
    endfunction

    AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R10
    AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R10
    AST_VL_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> ((res_mask & ~lim_of($past(lk_vl))) == '0)); // R9
    AST_UNPRED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !rd_en) |=> (res_mask == lim_of($past(lk_vl)) && !res_zero)); // R8
    AST_READ_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !rd_en); // R5
    AST_ZERO_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !rd_en) |=> !res_zero); // R7

endmodule

bind predmask_unit predmask_unit_chk #(.XLEN(XLEN), .VL_W(VL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vl     (lk_vl),
    .rd_en     (rd_en),
    .res_valid (res_valid),
    .res_mask  (res_mask),
    .res_zero  (res_zero)
);

// File: tb/predmask_unit_test.sv
module predmask_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 8;
    localparam int NUM_CFG    = 4;
    localparam int VL_W       = $clog2(XLEN + 1);
    localparam int CFG_AW     = $clog2(NUM_CFG);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_slot = '0;
    logic              cfg_used = 1'b0, cfg_is_fp = 1'b0, cfg_inv = 1'b0, cfg_zero = 1'b0;
    logic [4:0]        cfg_key = '0, cfg_src = '0;
    logic              rebuild = 1'b0;
    logic              lk_valid = 1'b0, lk_is_fp = 1'b0;
    logic [4:0]        lk_reg = '0;
    logic [VL_W-1:0]   lk_vl = '0;
    logic              rd_en;
    logic [4:0]        rd_addr;
    logic [XLEN-1:0]   rd_data;
    logic              res_valid;
    logic [XLEN-1:0]   res_mask;
    logic              res_zero;

    int tests = 0;
    int fails = 0;

    // Bench model: pending slots and slots applied at the last rebuild.
    bit       p_used[NUM_CFG], p_fp[NUM_CFG], p_inv[NUM_CFG], p_zero[NUM_CFG];
    int       p_key[NUM_CFG], p_src[NUM_CFG];
    bit       a_used[NUM_CFG], a_fp[NUM_CFG], a_inv[NUM_CFG], a_zero[NUM_CFG];
    int       a_key[NUM_CFG], a_src[NUM_CFG];

    always #(CLK_PERIOD/2) clk = ~clk;

    predmask_unit #(.XLEN(XLEN), .NUM_CFG(NUM_CFG)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_used(cfg_used), .cfg_is_fp(cfg_is_fp), .cfg_key(cfg_key),
        .cfg_src(cfg_src), .cfg_inv(cfg_inv), .cfg_zero(cfg_zero),
        .rebuild(rebuild), .lk_valid(lk_valid), .lk_is_fp(lk_is_fp),
        .lk_reg(lk_reg), .lk_vl(lk_vl), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .res_valid(res_valid), .res_mask(res_mask),
        .res_zero(res_zero)
    );

    function automatic logic [XLEN-1:0] regval(input int a);
        return XLEN'((a * 29 + 7) & 255);
    endfunction

    always_comb rd_data = regval(int'(rd_addr));

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic write_slot(input int s, input bit used, input bit fp, input int key,
                              input int src, input bit inv, input bit zr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = CFG_AW'(s); cfg_used = used; cfg_is_fp = fp;
        cfg_key = 5'(key); cfg_src = 5'(src); cfg_inv = inv; cfg_zero = zr;
        p_used[s] = used; p_fp[s] = fp; p_key[s] = key; p_src[s] = src;
        p_inv[s] = inv; p_zero[s] = zr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_rebuild();
        @(negedge clk);
        rebuild = 1'b1;
        @(negedge clk);
        rebuild = 1'b0;
        for (int s = 0; s < NUM_CFG; s++) begin
            a_used[s] = p_used[s]; a_fp[s] = p_fp[s]; a_key[s] = p_key[s];
            a_src[s] = p_src[s]; a_inv[s] = p_inv[s]; a_zero[s] = p_zero[s];
        end
    endtask

    // Lookup and compare with the requirement-derived expectation.
    task automatic lookup(input bit fp, input int key, input int vl);
        bit en = 0, inv = 0, zr = 0;
        int src = 0;
        logic [XLEN-1:0] base, lim, exp_mask;
        string tag;
        for (int s = 0; s < NUM_CFG; s++) begin
            if (a_used[s] && a_fp[s] == fp && a_key[s] == key) begin
                en = 1; src = a_src[s]; inv = a_inv[s]; zr = a_zero[s];
            end
        end
        base = !en ? '1 : (inv ? ~regval(src) : regval(src));
        lim  = (vl >= XLEN) ? '1 : XLEN'((1 << vl) - 1);
        exp_mask = base & lim;
        if (!fp && key == 7 && !en) tag = "R11";
        else if (!en)               tag = "R8";
        else if (vl < XLEN)         tag = "R9";
        else if (fp)                tag = "R4";
        else if (inv)               tag = "R6";
        else                        tag = "R3";
        lk_valid = 1'b1; lk_is_fp = fp; lk_reg = 5'(key); lk_vl = VL_W'(vl);
        #1;
        check("R5", "rd_en", rd_en, en);
        if (en) check("R5", "rd_addr", rd_addr, src);
        @(negedge clk);
        lk_valid = 1'b0;
        check("R10", "res_valid", res_valid, 1);
        check(tag, "res_mask", res_mask, exp_mask);
        check("R7", "res_zero", res_zero, en & zr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < NUM_CFG; s++) begin
            p_used[s] = 0; p_fp[s] = 0; p_key[s] = 0; p_src[s] = 0; p_inv[s] = 0; p_zero[s] = 0;
            a_used[s] = 0; a_fp[s] = 0; a_key[s] = 0; a_src[s] = 0; a_inv[s] = 0; a_zero[s] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1", "res_valid in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "res_valid after reset", res_valid, 0);
        // R1: empty tables before any rebuild
        for (int k = 0; k < 32; k++) lookup(k[0], k, XLEN);

        // Slot 2 overrides slot 0 on int key 3 (R3); slot 1 same key in fp (R4);
        // slot 3 unused on int key 7 (R11).
        write_slot(0, 1, 0, 3, 10, 0, 1);
        write_slot(1, 1, 1, 3, 20, 1, 0);
        write_slot(2, 1, 0, 3, 5, 1, 0);
        write_slot(3, 0, 0, 7, 9, 0, 1);
        // R2: writes alone change nothing
        lookup(0, 3, XLEN);
        lookup(1, 3, XLEN);
        do_rebuild();
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < 32; k++)
                for (int v = 0; v <= XLEN + 2; v++)
                    lookup(f[0], k, (v == XLEN + 2) ? 15 : v);

        // Reconfigure: old entries must vanish on rebuild (R3)
        write_slot(2, 0, 0, 3, 5, 1, 0);
        write_slot(1, 1, 1, 31, 0, 0, 1);
        write_slot(3, 1, 0, 0, 17, 0, 0);
        do_rebuild();
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < 32; k++) begin
                lookup(f[0], k, XLEN);
                lookup(f[0], k, 5);
            end

        // R10: idle cycles give no result
        repeat (2) @(negedge clk);
        check("R10", "res_valid idle", res_valid, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule